// File: doc/BRIEF.md
# Two-Segment Pipelined AES-128 Engine

This block encrypts or decrypts 128-bit blocks under a 128-bit key. It connects to a 32-bit data path, so each block arrives as four words and leaves as four words, with the most significant word first in both directions. Valid/ready handshakes sit on both sides, so an upstream source and a downstream sink can each stall the core.

Inside, the ten rounds are split between two registered segments. Each segment has one round circuit that it reuses on five consecutive clocks. A block first goes through the initial key addition, which draws on the first subkey of its direction. It then runs rounds one to five in the front segment. On the clock that completes round five it moves into the back segment, and the front segment can take a new block in that same clock. The back segment runs rounds six to ten and hands the result to the output word shifter. Word loading, word unloading and the two segments all work at the same time. The input side accepts at most four words in any five clocks, so the bus pace matches the segment pace.

The key is an input that stays stable while blocks are in flight. The whole subkey schedule is derived from it inside the block. A direction flag is captured with the first word of each block and stays attached to that block through both segments.

Top module: `aes_seg_pipe`

## Requirements
- R1: While reset is held and on the first clock after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A block is taken as four accepted input words. The first word supplies bits 127:96. `in_dir` is sampled only on that first word: 0 selects encryption and 1 selects decryption. Its value on the other three words has no effect.
- R3: With `in_dir`=0, the output block is the AES-128 encryption of the input block under `key`.
- R4: With `in_dir`=1, the output block is the AES-128 decryption of the input block under `key`.
- R5: The output block leaves as four words, bits 127:96 first. `out_valid` stays high and `out_data` stays stable while `out_ready` is low.
- R6: With no stalls, the first output word is accepted exactly 15 clocks after the first input word of the same block.
- R7: With a continuous source and sink, blocks start on the input every 5 clocks and results start on the output every 5 clocks. `in_ready` is low on the clock after each fourth word.
- R8: With `out_ready` held low, the core accepts exactly four whole blocks and then keeps `in_ready` low. When the sink resumes, all of those blocks come out correct and in order.
- R9: Blocks in flight at the same time may have different directions, and each block is processed in its own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key | input | 128 | Cipher key, held stable while blocks are in flight |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Core can take an input word |
| in_data | input | 32 | Input word, most significant word of a block first |
| in_dir | input | 1 | Direction, sampled on the first word: 0 encrypt, 1 decrypt |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | 32 | Output word, most significant word of a block first |

## Verification
The hardest case to produce is a full core: the output shifter, both segments and the input buffer all hold a block, and each segment is frozen on its last round waiting for the stage after it. The bench gets there by holding `out_ready` low while it keeps offering input words. It then confirms that exactly four blocks were taken and that the held output word does not move. After that it releases the sink and checks every result. Random stall patterns on both sides, with a random direction per block, then bring about partial stalls in every stage combination.

// File: rtl/aes_seg_pipe.sv
module aes_seg_pipe (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] key,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [31:0]  in_data,
  input  logic         in_dir,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [31:0]  out_data
);

  localparam int NROUND = 10;
  localparam int SEG    = NROUND / 2;
  localparam int CW     = $clog2(SEG);
  localparam logic [CW-1:0] LAST = CW'(SEG - 1);

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (8'h1b & {8{b[7]}});
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) r = gmul(r, p);
      p = gmul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = ginv(x);
    return v ^ rl(v, 1) ^ rl(v, 2) ^ rl(v, 3) ^ rl(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] isbox(input logic [7:0] x);
    return ginv(rl(x, 1) ^ rl(x, 3) ^ rl(x, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] mixcol(input logic [31:0] c, input logic inv);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    if (!inv)
      return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
              a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
              a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
              xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
            gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
            gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
            gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
  endfunction

  function automatic logic [128*(NROUND+1)-1:0] key_sched(input logic [127:0] k);
    logic [128*(NROUND+1)-1:0] ks;
    logic [31:0] w [4*(NROUND+1)];
    logic [31:0] t;
    logic [7:0]  rc;
    ks = '0;
    rc = 8'h01;
    for (int i = 0; i < 4*(NROUND+1); i++) begin
      if (i < 4) begin
        w[i] = k[127-32*i -: 32];
      end else begin
        t = w[i-1];
        if (i % 4 == 0) begin
          t = {sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0]), sbox(t[31:24])} ^ {rc, 24'h0};
          rc = xt(rc);
        end
        w[i] = w[i-4] ^ t;
      end
      ks[(i/4)*128 + 96 - 32*(i%4) +: 32] = w[i];
    end
    return ks;
  endfunction

  function automatic logic [127:0] do_round(input logic [127:0] s, input logic [3:0] r,
                                            input logic dec, input logic [128*(NROUND+1)-1:0] ks);
    logic [127:0] t, u, k;
    logic [3:0]   ki;
    int fs, is;
    ki = dec ? 4'(NROUND) - r : r;
    k  = ks[int'(ki)*128 +: 128];
    for (int i = 0; i < 16; i++) begin
      fs = (i % 4) + 4 * (((i / 4) + (i % 4)) % 4);
      is = (i % 4) + 4 * (((i / 4) + 4 - (i % 4)) % 4);
      t[127-8*i -: 8] = dec ? isbox(s[127-8*is -: 8]) : sbox(s[127-8*fs -: 8]);
    end
    u = dec ? (t ^ k) : t;
    if (r != 4'(NROUND))
      for (int c = 0; c < 4; c++) u[127-32*c -: 32] = mixcol(u[127-32*c -: 32], dec);
    return dec ? u : (u ^ k);
  endfunction

  logic [128*(NROUND+1)-1:0] ks;
  logic [127:0] ibuf, fst, bst, obuf, fnext, bnext, first_key;
  logic [1:0]   ibeat, obeat;
  logic [CW-1:0] fcnt, bcnt;
  logic         ifull, idir, fv, fdir, bv, bdir, ov;

  assign ks        = key_sched(key);
  assign first_key = idir ? ks[NROUND*128 +: 128] : ks[127:0];
  assign fnext     = do_round(fst, 4'(fcnt) + 4'd1, fdir, ks);
  assign bnext     = do_round(bst, 4'(bcnt) + 4'(SEG + 1), bdir, ks);

  wire in_fire    = in_valid && in_ready;
  wire out_fire   = out_valid && out_ready;
  wire out_acc    = !ov || (out_fire && obeat == 2'd3);
  wire back_done  = bv && bcnt == LAST;
  wire back_acc   = !bv || (back_done && out_acc);
  wire front_done = fv && fcnt == LAST;
  wire front_acc  = !fv || (front_done && back_acc);
  wire f2b        = front_done && back_acc;
  wire b2o        = back_done && out_acc;
  wire load       = ifull && front_acc;

  assign in_ready  = !ifull;
  assign out_valid = ov;
  assign out_data  = obuf[{~obeat, 5'b0} +: 32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibuf <= '0; ibeat <= '0; ifull <= 1'b0; idir <= 1'b0;
    end else begin
      if (in_fire) begin
        ibuf  <= {ibuf[95:0], in_data};
        ibeat <= ibeat + 2'd1;
        if (ibeat == 2'd0) idir <= in_dir;
        if (ibeat == 2'd3) ifull <= 1'b1;
      end
      if (load) ifull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst <= '0; fcnt <= '0; fdir <= 1'b0; fv <= 1'b0;
    end else if (load) begin
      fst <= ibuf ^ first_key; fcnt <= '0; fdir <= idir; fv <= 1'b1;
    end else if (f2b) begin
      fv <= 1'b0;
    end else if (fv && fcnt != LAST) begin
      fst <= fnext; fcnt <= fcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst <= '0; bcnt <= '0; bdir <= 1'b0; bv <= 1'b0;
    end else if (f2b) begin
      bst <= fnext; bcnt <= '0; bdir <= fdir; bv <= 1'b1;
    end else if (b2o) begin
      bv <= 1'b0;
    end else if (bv && bcnt != LAST) begin
      bst <= bnext; bcnt <= bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf <= '0; obeat <= '0; ov <= 1'b0;
    end else if (b2o) begin
      obuf <= bnext; obeat <= '0; ov <= 1'b1;
    end else if (out_fire) begin
      obeat <= obeat + 2'd1;
      if (obeat == 2'd3) ov <= 1'b0;
    end
  end

  AST_OUT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_OUT_START:   assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> obeat == 2'd0); // R5
  AST_FRONT_STALL: assert property (@(posedge clk) disable iff (!rst_n) front_done && !back_acc |=> front_done && $stable(fst)); // R8
  AST_BACK_STALL:  assert property (@(posedge clk) disable iff (!rst_n) back_done && !out_acc |=> back_done && $stable(bst)); // R8
  AST_FRONT_STEP:  assert property (@(posedge clk) disable iff (!rst_n) fv && !front_done |=> fv && fcnt == $past(fcnt) + 1'b1); // R6
  AST_BACK_STEP:   assert property (@(posedge clk) disable iff (!rst_n) bv && !back_done |=> bv && bcnt == $past(bcnt) + 1'b1); // R6
  AST_IDLE_SLOT:   assert property (@(posedge clk) disable iff (!rst_n) in_fire && ibeat == 2'd3 |=> !in_ready); // R7

endmodule

// File: tb/aes_seg_pipe_bench.sv
module aes_seg_pipe_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic [127:0] key;
  logic         in_valid, in_dir, out_ready;
  logic [31:0]  in_data;
  logic         in_ready, out_valid;
  logic [31:0]  out_data;

  aes_seg_pipe u_aes_seg_pipe (
    .clk(clk), .rst_n(rst_n), .key(key),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_dir(in_dir),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] sb [256];
  logic [7:0] isb [256];
  typedef logic [10:0][127:0] ks_t;

  logic [127:0] blk [256];
  logic [127:0] expq [256];
  bit           dq [256];
  int tin [256];
  int tout [256];
  int sent, got, ib, ob;
  logic [127:0] acc;
  bit hold_pend, last_fire;
  logic [31:0] hold_val;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] xt(input logic [7:0] b);
    return b[7] ? ((b << 1) ^ 8'h1b) : (b << 1);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic ks_t kexp(input logic [127:0] k);
    ks_t r;
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 44; i++) begin
      if (i < 4) w[i] = k[127-32*i -: 32];
      else begin
        t = w[i-1];
        if (i % 4 == 0) begin
          t = {sb[t[23:16]] ^ rc, sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
          rc = xt(rc);
        end
        w[i] = w[i-4] ^ t;
      end
    end
    for (int j = 0; j < 11; j++) r[j] = {w[4*j], w[4*j+1], w[4*j+2], w[4*j+3]};
    return r;
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] s, input int i);
    return s[127-8*i -: 8];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] k);
    ks_t rk = kexp(k);
    logic [127:0] s = pt ^ rk[0], t;
    logic [7:0] a [4];
    for (int r = 1; r <= 10; r++) begin
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++)
          t[127-8*(4*c+w) -: 8] = sb[gb(s, 4*((c+w)%4)+w)];
      if (r < 10)
        for (int c = 0; c < 4; c++) begin
          for (int w = 0; w < 4; w++) a[w] = gb(t, 4*c+w);
          for (int w = 0; w < 4; w++)
            t[127-8*(4*c+w) -: 8] = xt(a[w]) ^ xt(a[(w+1)%4]) ^ a[(w+1)%4] ^ a[(w+2)%4] ^ a[(w+3)%4];
        end
      s = t ^ rk[r];
    end
    return s;
  endfunction

  function automatic logic [127:0] ref_dec(input logic [127:0] ct, input logic [127:0] k);
    ks_t rk = kexp(k);
    logic [127:0] s = ct ^ rk[10], t;
    logic [7:0] a [4];
    for (int r = 9; r >= 0; r--) begin
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++)
          t[127-8*(4*((c+w)%4)+w) -: 8] = isb[gb(s, 4*c+w)];
      t = t ^ rk[r];
      if (r > 0)
        for (int c = 0; c < 4; c++) begin
          for (int w = 0; w < 4; w++) a[w] = gb(t, 4*c+w);
          for (int w = 0; w < 4; w++)
            t[127-8*(4*c+w) -: 8] = gm(a[w], 8'h0e) ^ gm(a[(w+1)%4], 8'h0b) ^
                                    gm(a[(w+2)%4], 8'h0d) ^ gm(a[(w+3)%4], 8'h09);
        end
      s = t;
    end
    return s;
  endfunction

  task automatic build_tables();
    logic [7:0] p = 8'h01, q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
  endtask

  task automatic prep_random(input int n, input int dirmode);
    for (int i = 0; i < n; i++) begin
      blk[i] = {$urandom, $urandom, $urandom, $urandom};
      dq[i]  = (dirmode == 2) ? bit'($urandom % 2) : bit'(i % 2);
      expq[i] = dq[i] ? ref_dec(blk[i], key) : ref_enc(blk[i], key);
    end
    sent = 0; got = 0; ib = 0; ob = 0;
  endtask

  task automatic run(input int n, input int pv, input int pr, input int lim);
    int spent = 0;
    bit infire, outfire;
    while (got < n && spent < lim) begin
      @(negedge clk);
      spent++;
      if (hold_pend)
        chk(out_valid && out_data == hold_val, "R5 hold", {96'd0, out_data}, {96'd0, hold_val});
      if (sent < n) begin
        if (!in_valid || last_fire) in_valid = (($urandom % 100) < pv);
        in_data = blk[sent][127-32*ib -: 32];
        in_dir  = (ib == 0) ? dq[sent] : bit'($urandom % 2);
      end else in_valid = 1'b0;
      out_ready = (($urandom % 100) < pr);
      infire  = in_valid && in_ready;
      outfire = out_valid && out_ready;
      hold_pend = out_valid && !out_ready;
      hold_val  = out_data;
      last_fire = infire;
      if (infire) begin
        if (ib == 0) tin[sent] = cyc;
        ib++;
        if (ib == 4) begin ib = 0; sent++; end
      end
      if (outfire) begin
        acc = {acc[95:0], out_data};
        if (ob == 0) tout[got] = cyc;
        ob++;
        if (ob == 4) begin
          ob = 0;
          chk(acc == expq[got], dq[got] ? "R4 R9 decrypt" : "R3 R9 encrypt", acc, expq[got]);
          got++;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    last_fire = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_dir = 1'b0; in_data = '0; out_ready = 1'b0;
    key = '0; hold_pend = 1'b0; last_fire = 1'b0; acc = '0;
    build_tables();
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 in reset", {126'd0, in_ready, out_valid}, 128'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", {126'd0, in_ready, out_valid}, 128'h2);

    // bench model against published answers
    chk(ref_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c)
        == 128'h3925841d02dc09fbdc118597196a0b32, "R3 model",
        ref_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c),
        128'h3925841d02dc09fbdc118597196a0b32);
    chk(ref_dec(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f)
        == 128'h00112233445566778899aabbccddeeff, "R4 model",
        ref_dec(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h000102030405060708090a0b0c0d0e0f),
        128'h00112233445566778899aabbccddeeff);

    // directed known answers through the core
    key = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    sent = 0; got = 0; ib = 0; ob = 0;
    blk[0] = 128'h3243f6a8885a308d313198a2e0370734; dq[0] = 1'b0;
    expq[0] = 128'h3925841d02dc09fbdc118597196a0b32;
    run(1, 100, 100, 200);
    chk(got == 1, "R3 known block out", 128'(got), 128'd1);

    key = 128'h000102030405060708090a0b0c0d0e0f;
    sent = 0; got = 0; ib = 0; ob = 0;
    blk[0] = 128'h00112233445566778899aabbccddeeff; dq[0] = 1'b0;
    expq[0] = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    blk[1] = 128'h69c4e0d86a7b0430d8cdb78070b4c55a; dq[1] = 1'b1;
    expq[1] = 128'h00112233445566778899aabbccddeeff;
    run(2, 100, 100, 200);
    chk(got == 2, "R2 R4 known pair out", 128'(got), 128'd2);

    // streaming: latency and 5-clock slot
    key = {$urandom, $urandom, $urandom, $urandom};
    prep_random(6, 1);
    repeat (2) @(negedge clk);
    run(6, 100, 100, 500);
    chk(tout[0] - tin[0] == 15, "R6 latency", 128'(tout[0] - tin[0]), 128'd15);
    for (int i = 1; i < 6; i++) begin
      chk(tin[i] - tin[i-1] == 5, "R7 input slot", 128'(tin[i] - tin[i-1]), 128'd5);
      chk(tout[i] - tout[i-1] == 5, "R7 output slot", 128'(tout[i] - tout[i-1]), 128'd5);
    end

    // back-pressure: core fills with four blocks
    key = {$urandom, $urandom, $urandom, $urandom};
    prep_random(8, 2);
    run(8, 100, 0, 80);
    chk(sent == 4 && ib == 0, "R8 blocks held", 128'(sent * 4 + ib), 128'd16);
    chk(in_ready == 1'b0 && out_valid == 1'b1, "R8 full state", {126'd0, in_ready, out_valid}, 128'h1);
    run(8, 100, 100, 2000);
    chk(got == 8, "R8 drained", 128'(got), 128'd8);

    // random stalls and mixed directions
    for (int pass = 0; pass < 3; pass++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      prep_random(40, 2);
      run(40, 30 + 30 * pass, 90 - 30 * pass, 20000);
      chk(got == 40, "R9 random run complete", 128'(got), 128'd40);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule